// File: doc/BRIEF.md
# Bi-phase Serial Word Transmitter

This block turns a 16-bit parallel word into a self-clocking bi-phase (Manchester II) frame and drives it onto one of two serial buses. A host presents the word, a sync-type flag and a bus choice, and pulses a one-cycle write strobe. The block captures all three on that strobe. It then emits a three-bit-time synchronisation pattern, the sixteen data bits with the most significant bit first, and a parity bit that it generates itself. The parity makes the 17-bit total odd.

Each line is driven as a complementary pair of positive and negative drive signals. A high level sets the positive drive to one and the negative drive to zero. A low level is the reverse. When neither drive is set, the line is left undriven. The bit timing comes from a 12 MHz clock: a half-cell is six clock cycles and a bit cell is one microsecond. A busy flag covers the whole frame. A write strobe that arrives while the flag is high is discarded.

Top module: `biphase_word_tx`

## Requirements
- R1: While reset is high, and after it is released with no write, busy is 0 and all four drive outputs are 0.
- R2: A half-cell lasts HALF_CYC clock cycles (6 by default, so a bit cell is 12 cycles or 1 us at 12 MHz). A frame is 20 bit times (240 cycles). The outputs begin the frame one cycle after the clock edge that accepts the write. Busy is high for exactly those 240 cycles.
- R3: A line level "high" is pos=1, neg=0, and "low" is pos=0, neg=1. With the sync flag at 1 (command sync), the first three half-cells are high and the next three are low.
- R4: With the sync flag at 0 (data sync), the first three half-cells are low and the next three are high.
- R5: After the sync, data bits are sent from bit 15 down to bit 0. A one is sent as a high half-cell followed by a low half-cell. A zero is sent as low then high.
- R6: The last bit cell carries a parity bit chosen so that the 16 data bits plus parity contain an odd number of ones. It is encoded like a data bit.
- R7: A bus-select value of 0 sends the frame on bus A and 1 sends it on bus B. The value is captured at the write. Later changes to the input do not move a frame in flight.
- R8: The drive pair of the unselected bus stays 0/0 throughout a frame. Between frames, all four drives are 0.
- R9: A write strobe while busy is high is ignored. It does not alter the frame in progress, and no frame follows from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 16 | Word to transmit |
| wr_cmd_sync | input | 1 | 1 selects command sync, 0 selects data sync |
| wr_chan_b | input | 1 | 0 selects bus A, 1 selects bus B |
| bus_a_pos | output | 1 | Bus A positive drive |
| bus_a_neg | output | 1 | Bus A negative drive |
| bus_b_pos | output | 1 | Bus B positive drive |
| bus_b_neg | output | 1 | Bus B negative drive |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench builds the block with its defaults: a 16-bit word, six-cycle half-cells and a three-half-cell sync. With these values a whole 240-cycle frame can be compared against an independently computed expectation on every clock cycle. A timer that is off by one cycle therefore shows up as drift well before the parity cell. The words are chosen to give both parity values, all-zero and mixed patterns, and both sync types on both buses. One frame has a write strobe and a bus-select change injected midway through it. Frames are also sent back to back at the earliest cycle a new write is allowed.

// File: rtl/biphase_pkg.sv
`timescale 1ns/1ps
package biphase_pkg;
  // One complementary drive pair for a line
  typedef struct packed {
    logic pos;
    logic neg;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{pos: 1'b0, neg: 1'b0};
endpackage

// File: rtl/bp_half_timer.sv
`timescale 1ns/1ps
module bp_half_timer #(
  parameter int HALF_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic half_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign half_end = run && (cnt == LAST);
endmodule

// File: rtl/bp_frame_shifter.sv
`timescale 1ns/1ps
module bp_frame_shifter #(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              cmd_sync,
  input  logic [DATA_W-1:0] data,
  input  logic              half_end,
  output logic              active,
  output logic              level
);
  localparam int PAT_W = 2 * SYNC_HALVES + 2 * (DATA_W + 1);
  localparam int LW    = $clog2(PAT_W);

  logic [PAT_W-1:0] built;
  logic [PAT_W-1:0] pat;
  logic [LW-1:0]    left;
  logic             par;

  // Build the full half-cell sequence for a new word
  always_comb begin
    built = '0;
    par   = ~(^data);
    for (int i = 0; i < SYNC_HALVES; i++) begin
      built[PAT_W-1-i]             = cmd_sync;
      built[PAT_W-1-SYNC_HALVES-i] = ~cmd_sync;
    end
    for (int b = 0; b < DATA_W; b++) begin
      built[PAT_W-1-2*SYNC_HALVES-2*b] = data[DATA_W-1-b];
      built[PAT_W-2-2*SYNC_HALVES-2*b] = ~data[DATA_W-1-b];
    end
    built[1] = par;
    built[0] = ~par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pat    <= '0;
      left   <= '0;
    end else if (load) begin
      active <= 1'b1;
      pat    <= built;
      left   <= LW'(PAT_W - 1);
    end else if (active && half_end) begin
      if (left == '0) begin
        active <= 1'b0;
      end else begin
        pat  <= pat << 1;
        left <= left - 1'b1;
      end
    end
  end

  assign level = pat[PAT_W-1];
endmodule

// File: rtl/bp_bus_steer.sv
`timescale 1ns/1ps
module bp_bus_steer
  import biphase_pkg::*;
#(
  parameter int N_BUS = 2,
  parameter int SEL_W = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  active,
  input  logic                  level,
  input  logic [SEL_W-1:0]      sel,
  output drive_t [N_BUS-1:0]    drv,
  output logic                  busy
);
  for (genvar g = 0; g < N_BUS; g++) begin : g_bus
    always_ff @(posedge clk) begin
      if (rst) begin
        drv[g] <= DRIVE_OFF;
      end else if (active && (sel == SEL_W'(g))) begin
        drv[g] <= '{pos: level, neg: ~level};
      end else begin
        drv[g] <= DRIVE_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= active;
  end
endmodule

// File: rtl/biphase_word_tx.sv
`timescale 1ns/1ps
module biphase_word_tx
  import biphase_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_CYC    = 6,
  parameter int SYNC_HALVES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmd_sync,
  input  logic              wr_chan_b,
  output logic              bus_a_pos,
  output logic              bus_a_neg,
  output logic              bus_b_pos,
  output logic              bus_b_neg,
  output logic              busy
);
  localparam int N_BUS = 2;

  logic         active;
  logic         level;
  logic         half_end;
  logic         accept;
  logic [0:0]   chan_q;
  drive_t [N_BUS-1:0] drv;

  // R9: a write is taken only when nothing is in flight
  assign accept = wr_en && !active && !busy;

  always_ff @(posedge clk) begin
    if (rst)         chan_q <= 1'b0;
    else if (accept) chan_q <= wr_chan_b;
  end

  bp_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (active),
    .half_end (half_end)
  );

  bp_frame_shifter #(.DATA_W(DATA_W), .SYNC_HALVES(SYNC_HALVES)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .cmd_sync (wr_cmd_sync),
    .data     (wr_data),
    .half_end (half_end),
    .active   (active),
    .level    (level)
  );

  bp_bus_steer #(.N_BUS(N_BUS), .SEL_W(1)) u_steer (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .level  (level),
    .sel    (chan_q),
    .drv    (drv),
    .busy   (busy)
  );

  assign bus_a_pos = drv[0].pos;
  assign bus_a_neg = drv[0].neg;
  assign bus_b_pos = drv[1].pos;
  assign bus_b_neg = drv[1].neg;
endmodule

// File: rtl/biphase_word_tx_chk.sv
`timescale 1ns/1ps
module biphase_word_tx_chk #(
  parameter int FRAME_CYC = 240
) (
  input logic clk,
  input logic rst,
  input logic bus_a_pos,
  input logic bus_a_neg,
  input logic bus_b_pos,
  input logic bus_b_neg,
  input logic busy
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  a_r3_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_a_pos && bus_a_neg) && !(bus_b_pos && bus_b_neg));

  a_r8_one_bus_only: assert property (@(posedge clk) disable iff (rst)
    !((bus_a_pos || bus_a_neg) && (bus_b_pos || bus_b_neg)));

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(bus_a_pos || bus_a_neg || bus_b_pos || bus_b_neg));

  a_r2_driven_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> $countones({bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg}) == 1);

  a_r7_bus_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((bus_b_pos || bus_b_neg) == $past(bus_b_pos || bus_b_neg)));

  a_r2_frame_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 16'(FRAME_CYC)));
endmodule

bind biphase_word_tx biphase_word_tx_chk #(
  .FRAME_CYC((2 * SYNC_HALVES + 2 * (DATA_W + 1)) * HALF_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_a_pos (bus_a_pos),
  .bus_a_neg (bus_a_neg),
  .bus_b_pos (bus_b_pos),
  .bus_b_neg (bus_b_neg),
  .busy      (busy)
);

// File: tb/test_biphase_word_tx.sv
`timescale 1ns/1ps
module test_biphase_word_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_cmd_sync = 1'b0;
  logic        wr_chan_b = 1'b0;
  logic        bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  biphase_word_tx i_biphase_word_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_cmd_sync(wr_cmd_sync), .wr_chan_b(wr_chan_b),
    .bus_a_pos(bus_a_pos), .bus_a_neg(bus_a_neg),
    .bus_b_pos(bus_b_pos), .bus_b_neg(bus_b_neg), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: {busy,a_pos,a_neg,b_pos,b_neg} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic half_level(input logic [15:0] d, input logic cmd, input int h);
    logic p;
    p = ~(^d);
    if (h < 3)       return cmd;
    else if (h < 6)  return ~cmd;
    else if (h < 38) return ((h - 6) % 2 == 0) ? d[15 - (h - 6) / 2] : ~d[15 - (h - 6) / 2];
    else             return (h == 38) ? p : ~p;
  endfunction

  function automatic string req_of(input logic cmd, input int h);
    if (h < 6)   return cmd ? "R3 command sync" : "R4 data sync";
    if (h < 38)  return "R5 data bits";
    return "R6 parity";
  endfunction

  function automatic logic [4:0] outs();
    return {busy, bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg};
  endfunction

  // Sends a frame and checks every cycle of it; optionally injects a write midway
  task automatic send_frame(input logic [15:0] d, input logic cmd, input logic chb, input int intr_at);
    logic [4:0] exp;
    logic       lv;
    wr_data = d; wr_cmd_sync = cmd; wr_chan_b = chb; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c < 240; c++) begin
      @(negedge clk);
      lv  = half_level(d, cmd, c / 6);
      exp = chb ? {1'b1, 2'b00, lv, ~lv} : {1'b1, lv, ~lv, 2'b00};
      check(outs() === exp, (c % 6 == 0) ? "R2 timing" : req_of(cmd, c / 6), outs(), exp);
      if (c == intr_at) begin
        // R9 and R7: new write plus bus change while busy
        wr_data = ~d; wr_cmd_sync = ~cmd; wr_chan_b = ~chb; wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    check(outs() === 5'b0, "R8 idle after frame", outs(), 5'b0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(outs() === 5'b0, "R1 during reset", outs(), 5'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(outs() === 5'b0, "R1 after reset", outs(), 5'b0);
  endtask

  task automatic test_quiet_after_ignored();
    bit ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (outs() !== 5'b0) ok = 1'b0;
    end
    check(ok, "R9 no frame from ignored write", outs(), 5'b0);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    send_frame(16'h0000, 1'b1, 1'b0, -1);   // command sync, bus A, parity 1
    send_frame(16'h0001, 1'b0, 1'b1, -1);   // data sync, bus B, parity 0
    send_frame(16'hA5C3, 1'b1, 1'b1, -1);   // back to back, even ones
    send_frame(16'h7FFE, 1'b0, 1'b0, 100);  // write + bus change mid-frame
    test_quiet_after_ignored();
    send_frame(16'h8000, 1'b0, 1'b0, -1);   // MSB first check
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule